// File: doc/BRIEF.md
# Watchdog Timer with Sleep Wake-Up

This block is a watchdog that runs from its own free-running clock, separate from the system clock. It keeps counting while the system clock is stopped for sleep. The count goes through a fixed base period of `2**BASE_W` watchdog-clock cycles. A postscaler then stretches that period by a power of two. If nothing restarts the count before it runs out, the block raises one of two requests. When the core is awake it raises a one-cycle system reset request. When the core reports that it is asleep it raises a one-cycle wake-up request, and no reset follows. In both cases a timeout status flag drops to 0.

Software keeps the watchdog quiet with a clear strobe. The sleep-entry strobe restarts the count in the same way. Each strobe starts a toggle handshake into the watchdog domain. There, both the base counter and the postscaler count go back to zero. The expiry event comes back to the system domain through a synchronizer. The system domain then turns it into a reset request or a wake-up request, depending on the sleep status at that moment.

There are two levels of enable. A hardwired enable input locks the watchdog on. When that input is low, bit 0 of an 8-bit control register decides whether the watchdog runs.

Top module: `wdt_wake_top`

## Requirements
- R1: With `hw_en_i` high the watchdog runs whatever the control register holds. With `hw_en_i` low it runs only while control bit 0 is 1, and it makes no request while stopped.
- R2: The control register is 8 bits wide and resets to 0. A write stores `ctrl_wdata_i[0]` in bit 0 and is visible on `ctrl_rdata_o` the next cycle. Bits 7..1 always read as 0.
- R3: When the count expires while `sleep_i` is 0, `rst_req_o` goes high for exactly one system-clock cycle and `wake_o` stays 0.
- R4: When the count expires while `sleep_i` is 1, `wake_o` goes high for exactly one system-clock cycle and `rst_req_o` stays 0. The two requests are never high together.
- R5: `to_flag_o` is 1 after reset and returns to 1 after a clear or sleep-entry strobe. It is 0 in the cycle an expiry request is raised. If an expiry and a strobe arrive in the same cycle, the expiry wins.
- R6: A clear strobe or a sleep-entry strobe returns the base counter and the postscaler count to zero. Strobes repeated within one period prevent any request.
- R7: The postscaler select `ps_sel_i` (3 bits, value s) sets the period to `2**BASE_W * 2**s` watchdog-clock cycles. The select is captured at the first watchdog-clock edge after watchdog reset, and later changes have no effect until the next reset.
- R8: After an expiry the count restarts from zero. While the watchdog keeps running, successive requests are exactly one full period apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | System-domain asynchronous reset, active low |
| wdt_clk | input | 1 | Free-running watchdog clock |
| wdt_rst_n | input | 1 | Watchdog-domain asynchronous reset, active low |
| hw_en_i | input | 1 | Hardwired enable; locks the watchdog on |
| ps_sel_i | input | 3 | Postscaler select, period multiplier 2**value |
| clr_stb_i | input | 1 | Clear-watchdog strobe, one system cycle |
| slp_stb_i | input | 1 | Sleep-entry strobe, one system cycle |
| sleep_i | input | 1 | Core sleep status |
| ctrl_we_i | input | 1 | Control register write enable |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register read data |
| rst_req_o | output | 1 | System reset request pulse |
| wake_o | output | 1 | Wake-up request pulse |
| to_flag_o | output | 1 | Timeout status flag, 0 after an expiry |

## Verification
The assertions assume that the clear and sleep-entry strobes last one system cycle. They also assume that a strobe never arrives while the previous handshake is still in flight; one assertion checks this. The requests are assumed to be looked at only after both resets are released. The stimulus spaces strobes about a hundred system cycles apart, which is far longer than the handshake round trip. It holds `sleep_i` steady across each expiry window, so that the choice between reset and wake-up is well defined. The two clocks have fixed, distinct phases, so no watchdog edge ever lands on a system edge.

// File: rtl/wdt_wake_pkg.sv
package wdt_wake_pkg;

  // Terminal postscaler count for a select value: 2**sel - 1.
  function automatic int unsigned ps_limit(input int unsigned sel);
    return (32'd1 << sel) - 32'd1;
  endfunction

endpackage

// File: rtl/wdt_wake_sync.sv
module wdt_wake_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  // Two-flop synchronizer, one chain per bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/wdt_wake_core.sv
module wdt_wake_core #(
  parameter int BASE_W   = 6,
  parameter int PS_SEL_W = 3
) (
  input  logic                wdt_clk,
  input  logic                wdt_rst_n,
  input  logic [PS_SEL_W-1:0] ps_sel_i,
  input  logic                en_lvl_i,
  input  logic                kick_lvl_i,
  output logic                ack_lvl_o,
  output logic                exp_tgl_o,
  output logic                kick_w_o,
  output logic                expire_w_o,
  output logic                run_en_o,
  output logic                cnt_idle_o
);
  import wdt_wake_pkg::*;

  localparam int POST_W = (1 << PS_SEL_W) - 1;
  localparam logic [BASE_W-1:0] BASE_MAX = {BASE_W{1'b1}};

  logic                en_s, kick_s, kick_d;
  logic                loaded_q, exp_q;
  logic [PS_SEL_W-1:0] ps_q;
  logic [BASE_W-1:0]   base_q;
  logic [POST_W-1:0]   post_q;
  logic [POST_W-1:0]   post_lim;
  logic                kick_w, expire_w;

  wdt_wake_sync #(.W(2)) u_in_sync (
    .clk   (wdt_clk),
    .rst_n (wdt_rst_n),
    .d     ({en_lvl_i, kick_lvl_i}),
    .q     ({en_s, kick_s})
  );

  assign post_lim = POST_W'(ps_limit(32'(ps_q)));
  assign kick_w   = kick_s ^ kick_d;
  assign expire_w = loaded_q && en_s && !kick_w &&
                    (base_q == BASE_MAX) && (post_q == post_lim);

  always_ff @(posedge wdt_clk or negedge wdt_rst_n) begin
    if (!wdt_rst_n) begin
      ps_q     <= '0;
      loaded_q <= 1'b0;
      base_q   <= '0;
      post_q   <= '0;
      kick_d   <= 1'b0;
      exp_q    <= 1'b0;
    end else begin
      kick_d <= kick_s;
      if (!loaded_q) begin
        ps_q     <= ps_sel_i;
        loaded_q <= 1'b1;
      end else if (kick_w || !en_s) begin
        base_q <= '0;
        post_q <= '0;
      end else if (expire_w) begin
        base_q <= '0;
        post_q <= '0;
        exp_q  <= ~exp_q;
      end else if (base_q == BASE_MAX) begin
        base_q <= '0;
        post_q <= post_q + POST_W'(1);
      end else begin
        base_q <= base_q + BASE_W'(1);
      end
    end
  end

  assign ack_lvl_o  = kick_d;
  assign exp_tgl_o  = exp_q;
  assign kick_w_o   = kick_w;
  assign expire_w_o = expire_w;
  assign run_en_o   = en_s;
  assign cnt_idle_o = (base_q == '0) && (post_q == '0);
endmodule

// File: rtl/wdt_wake_sysif.sv
module wdt_wake_sysif #(
  parameter int CTRL_W = 8
) (
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              clr_stb_i,
  input  logic              slp_stb_i,
  input  logic              sleep_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              ack_lvl_i,
  input  logic              exp_tgl_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  output logic              sw_en_o,
  output logic              kick_lvl_o,
  output logic              busy_o,
  output logic              rst_req_o,
  output logic              wake_o,
  output logic              to_flag_o
);
  localparam logic [CTRL_W-1:0] CTRL_MASK = CTRL_W'(1);

  logic [CTRL_W-1:0] ctrl_q;
  logic              req_q, again_q;
  logic              ack_s, exp_s, exp_d;
  logic              kick, busy, exp_ev;

  wdt_wake_sync #(.W(2)) u_back_sync (
    .clk   (sys_clk),
    .rst_n (sys_rst_n),
    .d     ({ack_lvl_i, exp_tgl_i}),
    .q     ({ack_s, exp_s})
  );

  assign kick   = clr_stb_i | slp_stb_i;
  assign busy   = req_q ^ ack_s;
  assign exp_ev = exp_s ^ exp_d;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      ctrl_q    <= '0;
      req_q     <= 1'b0;
      again_q   <= 1'b0;
      exp_d     <= 1'b0;
      rst_req_o <= 1'b0;
      wake_o    <= 1'b0;
      to_flag_o <= 1'b1;
    end else begin
      exp_d <= exp_s;
      if (ctrl_we_i) ctrl_q <= ctrl_wdata_i & CTRL_MASK;
      // Toggle handshake; a strobe during a transfer is replayed after ack.
      if (kick) begin
        if (!busy) req_q   <= ~req_q;
        else       again_q <= 1'b1;
      end else if (again_q && !busy) begin
        req_q   <= ~req_q;
        again_q <= 1'b0;
      end
      rst_req_o <= exp_ev && !sleep_i;
      wake_o    <= exp_ev && sleep_i;
      if (exp_ev)    to_flag_o <= 1'b0;
      else if (kick) to_flag_o <= 1'b1;
    end
  end

  assign ctrl_rdata_o = ctrl_q;
  assign sw_en_o      = ctrl_q[0];
  assign kick_lvl_o   = req_q;
  assign busy_o       = busy;
endmodule

// File: rtl/wdt_wake_top.sv
module wdt_wake_top #(
  parameter int BASE_W   = 6,
  parameter int PS_SEL_W = 3,
  parameter int CTRL_W   = 8
) (
  input  logic                sys_clk,
  input  logic                sys_rst_n,
  input  logic                wdt_clk,
  input  logic                wdt_rst_n,
  input  logic                hw_en_i,
  input  logic [PS_SEL_W-1:0] ps_sel_i,
  input  logic                clr_stb_i,
  input  logic                slp_stb_i,
  input  logic                sleep_i,
  input  logic                ctrl_we_i,
  input  logic [CTRL_W-1:0]   ctrl_wdata_i,
  output logic [CTRL_W-1:0]   ctrl_rdata_o,
  output logic                rst_req_o,
  output logic                wake_o,
  output logic                to_flag_o
);
  logic sw_en, en_lvl, kick_lvl, ack_lvl, exp_tgl;
  logic kick_busy, kick_w, expire_w, run_en_w, cnt_idle;

  // Hardwired enable overrides; software bit matters only when it is low.
  assign en_lvl = hw_en_i | sw_en;

  wdt_wake_sysif #(.CTRL_W(CTRL_W)) u_sys (
    .sys_clk      (sys_clk),
    .sys_rst_n    (sys_rst_n),
    .clr_stb_i    (clr_stb_i),
    .slp_stb_i    (slp_stb_i),
    .sleep_i      (sleep_i),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .ack_lvl_i    (ack_lvl),
    .exp_tgl_i    (exp_tgl),
    .ctrl_rdata_o (ctrl_rdata_o),
    .sw_en_o      (sw_en),
    .kick_lvl_o   (kick_lvl),
    .busy_o       (kick_busy),
    .rst_req_o    (rst_req_o),
    .wake_o       (wake_o),
    .to_flag_o    (to_flag_o)
  );

  wdt_wake_core #(.BASE_W(BASE_W), .PS_SEL_W(PS_SEL_W)) u_core (
    .wdt_clk    (wdt_clk),
    .wdt_rst_n  (wdt_rst_n),
    .ps_sel_i   (ps_sel_i),
    .en_lvl_i   (en_lvl),
    .kick_lvl_i (kick_lvl),
    .ack_lvl_o  (ack_lvl),
    .exp_tgl_o  (exp_tgl),
    .kick_w_o   (kick_w),
    .expire_w_o (expire_w),
    .run_en_o   (run_en_w),
    .cnt_idle_o (cnt_idle)
  );
endmodule

// File: rtl/wdt_wake_chk.sv
module wdt_wake_chk #(
  parameter int CTRL_W = 8
) (
  input logic              sys_clk,
  input logic              sys_rst_n,
  input logic              wdt_clk,
  input logic              wdt_rst_n,
  input logic              clr_stb_i,
  input logic              slp_stb_i,
  input logic              ctrl_we_i,
  input logic [CTRL_W-1:0] ctrl_wdata_i,
  input logic [CTRL_W-1:0] ctrl_rdata_o,
  input logic              rst_req_o,
  input logic              wake_o,
  input logic              to_flag_o,
  input logic              kick_busy,
  input logic              kick_w,
  input logic              expire_w,
  input logic              run_en_w,
  input logic              cnt_idle
);
  p_wr_visible_r2: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    ctrl_we_i |=> (ctrl_rdata_o == {{(CTRL_W-1){1'b0}}, $past(ctrl_wdata_i[0])}));

  p_single_rst_r3: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    rst_req_o |=> !rst_req_o);

  p_one_kind_r4: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !(rst_req_o && wake_o));

  p_flag_low_r5: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (rst_req_o || wake_o) |-> !to_flag_o);

  // Input assumption: no strobe while the handshake is still in flight (R6).
  p_kick_spacing_r6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (clr_stb_i || slp_stb_i) |-> !kick_busy);

  p_kick_clears_r6: assert property (@(posedge wdt_clk) disable iff (!wdt_rst_n)
    kick_w |=> cnt_idle);

  p_stopped_idle_r1: assert property (@(posedge wdt_clk) disable iff (!wdt_rst_n)
    !run_en_w |=> cnt_idle);

  p_restart_r8: assert property (@(posedge wdt_clk) disable iff (!wdt_rst_n)
    expire_w |=> cnt_idle);
endmodule

bind wdt_wake_top wdt_wake_chk #(.CTRL_W(CTRL_W)) u_chk (
  .sys_clk      (sys_clk),
  .sys_rst_n    (sys_rst_n),
  .wdt_clk      (wdt_clk),
  .wdt_rst_n    (wdt_rst_n),
  .clr_stb_i    (clr_stb_i),
  .slp_stb_i    (slp_stb_i),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .ctrl_rdata_o (ctrl_rdata_o),
  .rst_req_o    (rst_req_o),
  .wake_o       (wake_o),
  .to_flag_o    (to_flag_o),
  .kick_busy    (kick_busy),
  .kick_w       (kick_w),
  .expire_w     (expire_w),
  .run_en_w     (run_en_w),
  .cnt_idle     (cnt_idle)
);

// File: tb/tb_wdt_wake_top.sv
module tb_wdt_wake_top;
  localparam int BASE_W = 6;

  logic       sys_clk = 1'b0, wdt_clk = 1'b0;
  logic       sys_rst_n = 1'b0, wdt_rst_n = 1'b0;
  logic       hw_en = 1'b0, clr = 1'b0, slp = 1'b0, sleep = 1'b0, we = 1'b0;
  logic [2:0] ps_sel = 3'd1;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rst_req, wake, to_flag;

  wdt_wake_top dut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wdt_clk(wdt_clk), .wdt_rst_n(wdt_rst_n),
    .hw_en_i(hw_en), .ps_sel_i(ps_sel), .clr_stb_i(clr), .slp_stb_i(slp),
    .sleep_i(sleep), .ctrl_we_i(we), .ctrl_wdata_i(wdata), .ctrl_rdata_o(rdata),
    .rst_req_o(rst_req), .wake_o(wake), .to_flag_o(to_flag)
  );

  // 50 MHz system clock; watchdog clock 12.5 MHz at a phase that never meets it.
  always #10 sys_clk = ~sys_clk;
  initial begin
    #5;
    forever begin wdt_clk = 1'b1; #40; wdt_clk = 1'b0; #40; end
  end

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // Behavioural reference: toggles, delay queues and integer counters.
  int m_tgl, m_exp, m_swen, m_flag, m_rst, m_wake;
  int kq[$], eq[$], xq[$];
  int m_base, m_post, m_ps, m_loaded;

  always @(posedge sys_clk) begin
    if (!sys_rst_n) begin
      m_tgl = 0; m_swen = 0; m_flag = 1; m_rst = 0; m_wake = 0;
      xq = '{0, 0, 0};
    end else begin
      bit ev;
      ev = (xq[1] != xq[2]);
      m_rst  = (ev && !sleep) ? 1 : 0;
      m_wake = (ev && sleep) ? 1 : 0;
      if (ev) m_flag = 0;
      else if (clr || slp) m_flag = 1;
      if (clr || slp) m_tgl ^= 1;
      if (we) m_swen = wdata[0];
      void'(xq.pop_back());
      xq.push_front(m_exp);
    end
  end

  always @(posedge wdt_clk) begin
    if (!wdt_rst_n) begin
      m_exp = 0; m_base = 0; m_post = 0; m_ps = 0; m_loaded = 0;
      kq = '{0, 0, 0}; eq = '{0, 0};
    end else begin
      bit kick, en;
      kick = (kq[1] != kq[2]);
      en   = (eq[1] != 0);
      if (!m_loaded) begin
        m_ps = ps_sel; m_loaded = 1;
      end else if (kick || !en) begin
        m_base = 0; m_post = 0;
      end else if (m_base == 2**BASE_W - 1 && m_post == 2**m_ps - 1) begin
        m_base = 0; m_post = 0; m_exp ^= 1;
      end else if (m_base == 2**BASE_W - 1) begin
        m_base = 0; m_post++;
      end else m_base++;
      void'(kq.pop_back()); kq.push_front(m_tgl);
      void'(eq.pop_back()); eq.push_front((hw_en || m_swen != 0) ? 1 : 0);
    end
  end

  // Per-cycle compare, plus pulse counters and interval measurement.
  int cyc = 0, n_rst = 0, n_wake = 0, last_rst = -1, last_iv = -1;
  always @(negedge sys_clk) begin
    cyc++;
    check("R3 rst_req", int'(rst_req), m_rst);
    check("R4 wake", int'(wake), m_wake);
    check("R5 to_flag", int'(to_flag), m_flag);
    check("R2 ctrl_rdata", int'(rdata), m_swen);
    if (rst_req) begin
      n_rst++;
      if (last_rst >= 0) last_iv = cyc - last_rst;
      last_rst = cyc;
    end
    if (wake) n_wake++;
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge sys_clk);
  endtask

  task automatic strobe(input bit is_sleep);
    @(negedge sys_clk);
    if (is_sleep) slp = 1'b1; else clr = 1'b1;
    @(negedge sys_clk);
    slp = 1'b0; clr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge sys_clk); we = 1'b1; wdata = v;
    @(negedge sys_clk); we = 1'b0; wdata = 8'h00;
  endtask

  task automatic clear_counts;
    n_rst = 0; n_wake = 0; last_rst = -1; last_iv = -1;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    wait_cyc(5);
    sys_rst_n = 1'b1; wdt_rst_n = 1'b1;
    wait_cyc(2);
    // Reset state (R2, R5).
    check("R2 reset rdata", int'(rdata), 0);
    check("R5 reset flag", int'(to_flag), 1);

    // R1: both enables low, nothing happens.
    clear_counts();
    wait_cyc(1500);
    check("R1 stopped rst count", n_rst, 0);

    // R2: only bit 0 is stored. R7: later select change ignored.
    wr(8'hA5);
    check("R2 masked read", int'(rdata), 1);
    ps_sel = 3'd3;
    clear_counts();
    wait_cyc(1400);
    check("R1 sw enable runs", int'(n_rst >= 2), 1);
    check("R7 R8 interval sel1", last_iv, 4 * 64 * 2);
    check("R5 flag after expiry", int'(to_flag), 0);

    // R6: regular clears keep it quiet; flag returns to 1.
    clear_counts();
    for (int k = 0; k < 20; k++) begin
      strobe(1'b0);
      wait_cyc(98);
    end
    check("R6 no rst while cleared", n_rst, 0);
    check("R5 flag after clear", int'(to_flag), 1);

    // R4: asleep at expiry gives wake-up only.
    @(negedge sys_clk); sleep = 1'b1;
    clear_counts();
    strobe(1'b1);
    wait_cyc(800);
    check("R4 wake count", int'(n_wake >= 1), 1);
    check("R4 no rst in sleep", n_rst, 0);
    check("R5 flag after wake", int'(to_flag), 0);

    // R1: hardwired enable holds it on after software clears bit 0.
    @(negedge sys_clk); sleep = 1'b0;
    hw_en = 1'b1;
    wr(8'h00);
    check("R2 cleared read", int'(rdata), 0);
    clear_counts();
    wait_cyc(1200);
    check("R1 hw lock rst count", int'(n_rst >= 2), 1);

    // R7: new select captured at reset.
    @(negedge sys_clk); sys_rst_n = 1'b0; wdt_rst_n = 1'b0; ps_sel = 3'd2;
    wait_cyc(5);
    sys_rst_n = 1'b1; wdt_rst_n = 1'b1;
    clear_counts();
    wait_cyc(2700);
    check("R7 R8 interval sel2", last_iv, 4 * 64 * 4);
    check("R3 rst pulses sel2", n_rst, 2);

    done = 1'b1;
    finish_run();
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      finish_run();
    end
  end
endmodule